// File: doc/BRIEF.md
# NTT-Domain Pointwise Polynomial Multiplier

This block multiplies two 256-coefficient polynomials that are already in the number-theoretic-transform domain, modulo 3329. The coefficients are grouped into 128 degree-1 pairs. Each pair of one operand is multiplied by the matching pair of the other operand, reduced by the pair's own twiddle constant.

A caller pulses `start` while the block is idle. It then streams both operands in together, one coefficient of each per accepted cycle. The block computes one result coefficient per cycle for 256 cycles and raises `done` for one cycle. The results then stay readable by index through a combinational read port. They remain readable until the next compute phase overwrites them.

The twiddle constants are fixed and are computed at elaboration. No memory outside the block is used.

Top module: `ntt_pointwise_mul`

## Requirements
- R1: Every result coefficient read from `rd_data` lies in [0, 3328] when all loaded operands lie in [0, 3328].
- R2: While `rst` is high, and in the cycle after it falls, `busy` and `done` are both low. A reset in the middle of a job abandons the job.
- R3: A `start` pulse while idle raises `busy` from the next cycle. Load cycles then accept one `ld_a`/`ld_b` pair per cycle in which `ld_valid` is high, at indices 0, 1, …, 255 in that order. Cycles with `ld_valid` low accept nothing.
- R4: Acceptance of the 256th coefficient is followed by exactly 256 compute cycles. `done` is high for exactly one cycle, the cycle after the 256th compute edge. The cycle after that, `busy` and `done` are both low.
- R5: For pair k, made of indices 2k and 2k+1, result index 2k equals (a[2k]·b[2k] + a[2k+1]·b[2k+1]·z[k]) mod 3329.
- R6: Result index 2k+1 equals (a[2k]·b[2k+1] + a[2k+1]·b[2k]) mod 3329.
- R7: The twiddle z[k] equals 17^(2·rev(k)+1) mod 3329, where rev reverses the 7 bits of k.
- R8: A `start` pulse during load or compute has no effect: the load order, the results and the `done` timing are unchanged.
- R9: Sums that reach or exceed 3329 are reduced by exactly one subtraction of 3329, including the case where every operand is 3328.
- R10: The results stay readable, unchanged, from `done` until the next compute phase, including the whole of a following load phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; honoured only when idle |
| ld_valid | input | 1 | Load coefficient pair present this cycle |
| ld_a | input | 12 | Operand A coefficient |
| ld_b | input | 12 | Operand B coefficient |
| rd_idx | input | 8 | Result index to read |
| rd_data | output | 12 | Result coefficient at `rd_idx` |
| busy | output | 1 | High whenever not idle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench inserts random stalls between load cycles. A design that advanced its load index on idle cycles would shift every operand and corrupt whole pairs.

All-maximum and all-zero operands probe the single correction step. A missed correction would yield values of 3329 or more.

Operands whose only nonzero entries are the odd-index coefficients, set to 1, make each even result equal its twiddle. This exposes a twiddle table built with the wrong bit reversal or exponent.

Stray `start` pulses during busy phases, a reset in the middle of a job, and reads taken during the next load catch a controller that restarts, shortens its compute phase or overwrites results early.

// File: rtl/ntt_pointwise_mul.sv
module ntt_pointwise_mul #(
  parameter int W     = 12,
  parameter int N     = 256,
  parameter int Q     = 3329,
  parameter int ZROOT = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 ld_valid,
  input  logic [W-1:0]         ld_a,
  input  logic [W-1:0]         ld_b,
  input  logic [$clog2(N)-1:0] rd_idx,
  output logic [W-1:0]         rd_data,
  output logic                 busy,
  output logic                 done
);
  localparam int AW    = $clog2(N);
  localparam int PW    = AW - 1;
  localparam int NP    = N / 2;
  localparam int DW    = 2 * W;
  localparam int TW    = 4 * W;
  localparam int BK    = 2 * W;
  localparam longint BM = (longint'(1) << BK) / Q;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_COMP, S_DONE} st_t;
  st_t st;
  logic [AW-1:0] cnt;

  function automatic int zeta_of(input int idx);
    int e, r;
    e = 0;
    for (int j = 0; j < PW; j++) e = e | (((idx >> j) & 1) << (PW - 1 - j));
    e = 2 * e + 1;
    r = 1;
    for (int j = 0; j < e; j++) r = (r * ZROOT) % Q;
    return r;
  endfunction

  function automatic logic [W-1:0] mred(input logic [DW-1:0] p);
    logic [TW-1:0] t;
    logic [DW-1:0] qv, rv;
    t  = TW'(p) * TW'(BM);
    qv = DW'(t >> BK);
    rv = p - DW'(qv * DW'(Q));
    return (rv >= DW'(Q)) ? W'(rv - DW'(Q)) : W'(rv);
  endfunction

  function automatic logic [W-1:0] addm(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return (s >= (W+1)'(Q)) ? W'(s - (W+1)'(Q)) : W'(s);
  endfunction

  logic [W-1:0] ztab [NP];
  for (genvar g = 0; g < NP; g++) begin : g_zeta
    localparam int ZV = zeta_of(g);
    assign ztab[g] = W'(ZV);
  end

  logic [W-1:0] amem [N];
  logic [W-1:0] bmem [N];
  logic [W-1:0] cmem [N];

  wire [PW-1:0] pr = cnt[AW-1:1];
  wire [W-1:0] a0 = amem[{pr, 1'b0}];
  wire [W-1:0] a1 = amem[{pr, 1'b1}];
  wire [W-1:0] b0 = bmem[{pr, 1'b0}];
  wire [W-1:0] b1 = bmem[{pr, 1'b1}];
  wire [W-1:0] zt = ztab[pr];

  wire [W-1:0] p00 = mred(DW'(a0) * DW'(b0));
  wire [W-1:0] p11 = mred(DW'(a1) * DW'(b1));
  wire [W-1:0] p1z = mred(DW'(p11) * DW'(zt));
  wire [W-1:0] p01 = mred(DW'(a0) * DW'(b1));
  wire [W-1:0] p10 = mred(DW'(a1) * DW'(b0));
  wire [W-1:0] c0  = addm(p00, p1z);
  wire [W-1:0] c1  = addm(p01, p10);
  wire [W-1:0] res = cnt[0] ? c1 : c0;

  always_ff @(posedge clk) begin
    if (st == S_LOAD && ld_valid) begin
      amem[cnt] <= ld_a;
      bmem[cnt] <= ld_b;
    end
    if (st == S_COMP) cmem[cnt] <= res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_LOAD;
          cnt <= '0;
        end
        S_LOAD: if (ld_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == AW'(N - 1)) st <= S_COMP;
        end
        S_COMP: begin
          cnt <= cnt + 1'b1;
          if (cnt == AW'(N - 1)) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_data = cmem[rd_idx];
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_DONE);

  p_wr_range_r1: assert property (@(posedge clk) disable iff (rst)
    (st == S_COMP) |-> (res < W'(Q)));
  p_sum_fix_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_COMP) |-> (c0 < W'(Q) && c1 < W'(Q)));
  p_load_step_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOAD && ld_valid && cnt != AW'(N - 1)) |=> (st == S_LOAD && cnt == $past(cnt) + 1'b1));
  p_load_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOAD && !ld_valid) |=> (st == S_LOAD && $stable(cnt)));
  p_comp_len_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_COMP && cnt != AW'(N - 1)) |=> (st == S_COMP && cnt == $past(cnt) + 1'b1));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_COMP && start) |=> (st != S_LOAD));
endmodule

// File: tb/sim_ntt_pointwise_mul.sv
module sim_ntt_pointwise_mul;
  localparam int Q = 3329;
  logic clk = 0, rst = 1, start = 0, ld_valid = 0;
  logic [11:0] ld_a = 0, ld_b = 0, rd_data;
  logic [7:0] rd_idx = 0;
  logic busy, done;
  int checks = 0, errors = 0;
  int va [256], vb [256], prev [256];
  bit have_prev = 0, finished = 0;

  ntt_pointwise_mul u0 (.clk(clk), .rst(rst), .start(start), .ld_valid(ld_valid),
    .ld_a(ld_a), .ld_b(ld_b), .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy), .done(done));

  always #10 clk = ~clk;

  function automatic longint zeta(input int k);
    int e = 0;
    longint r = 1;
    for (int j = 0; j < 7; j++) e = e | (((k >> j) & 1) << (6 - j));
    e = 2 * e + 1;
    for (int j = 0; j < e; j++) r = (r * 17) % Q;
    return r;
  endfunction

  function automatic int expect_c(input int j);
    int k = j / 2;
    longint a0 = va[2*k], a1 = va[2*k+1], b0 = vb[2*k], b1 = vb[2*k+1];
    if (j % 2 == 0) return int'((a0 * b0 + ((a1 * b1) % Q) * zeta(k)) % Q);
    return int'((a0 * b1 + a1 * b0) % Q);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_job(input int stall_pct, input bit poke, input string tag);
    int early = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R3 busy after start", busy, 1);
    if (have_prev) begin
      rd_idx = 8'd5; #1;
      chk("R10 result kept during load", rd_data, prev[5]);
    end
    for (int i = 0; i < 256; i++) begin
      while (($urandom % 100) < stall_pct) begin
        ld_valid = 0; ld_a = 12'hfff; ld_b = 12'hfff; start = poke;
        @(negedge clk); start = 0;
      end
      ld_valid = 1; ld_a = 12'(va[i]); ld_b = 12'(vb[i]);
      @(negedge clk);
    end
    ld_valid = 0; start = poke;
    for (int n = 1; n < 256; n++) begin
      @(negedge clk); start = 0;
      if (done) early++;
    end
    chk("R4 no early done", early, 0);
    @(negedge clk);
    chk("R4 done after 256 compute cycles", done, 1);
    @(negedge clk);
    chk("R4 done one cycle", {done, busy}, 0);
    for (int j = 0; j < 256; j++) begin
      rd_idx = 8'(j); #1;
      prev[j] = expect_c(j);
      if (rd_data >= 12'(Q)) chk("R1 range", rd_data, 0);
      chk($sformatf("%s %s idx %0d", tag, (j % 2 == 0) ? "R5" : "R6", j), rd_data, prev[j]);
    end
    have_prev = 1;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R2 reset busy", busy, 0);
    chk("R2 reset done", done, 0);
    rst = 0;
    @(negedge clk);
    chk("R2 idle after reset", {busy, done}, 0);

    for (int i = 0; i < 256; i++) begin va[i] = $urandom % Q; vb[i] = $urandom % Q; end
    run_job(0, 0, "random");
    for (int i = 0; i < 256; i++) begin va[i] = $urandom % Q; vb[i] = $urandom % Q; end
    run_job(30, 0, "R3 stalls");
    for (int i = 0; i < 256; i++) begin va[i] = Q - 1; vb[i] = Q - 1; end
    run_job(10, 0, "R9 max");
    for (int i = 0; i < 256; i++) begin va[i] = 0; vb[i] = 0; end
    run_job(0, 0, "R9 zero");
    for (int i = 0; i < 256; i++) begin va[i] = i % 2; vb[i] = i % 2; end
    run_job(0, 0, "R7 twiddle");
    for (int i = 0; i < 256; i++) begin va[i] = $urandom % Q; vb[i] = $urandom % Q; end
    run_job(20, 1, "R8 stray start");

    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    ld_valid = 1;
    repeat (10) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0; ld_valid = 0;
    @(negedge clk);
    chk("R2 reset mid job", {busy, done}, 0);
    for (int i = 0; i < 256; i++) begin va[i] = $urandom % Q; vb[i] = $urandom % Q; end
    run_job(5, 0, "after reset");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule